// File: doc/BRIEF.md
# Smartcard Character Transmitter with Parity-Error Acknowledge Check

This block sends one character at a time over a single half-duplex I/O line that it shares with a smart card. A start strobe loads a byte. The block then sends a low start bit, the eight data bits least significant first, and an even parity bit. Every bit lasts sixteen pulses of an external 16x oversampling tick. While these bits go out, the block asserts a separate output-enable, so the pad actively drives the line.

For the stop time of one and a half bit periods, the block drops the output-enable and presents a high level. A weak pull-up then holds the line, and the card can pull it low to signal a parity error. The block samples the returned line value at the 16th, 17th and 18th oversampling ticks of the stop time. It takes a two-of-three majority of those samples and holds the verdict in a flag until the next character starts. A done pulse marks the end of each character. The line sampling and the baud tick come from outside the block.

The block also makes a free-running card clock from the system clock. A 5-bit prescale value sets the division ratio, and the card clock runs independently of the character timing.

Top module: `sc_char_tx`

## Requirements
- R1: After reset, tx_o is 1 and oe_o, busy_o, nack_o, done_o and card_clk_o are all 0.
- R2: A start_i seen at a clock edge while busy_o is 0 is accepted at that edge. From the next cycle, busy_o is 1, tx_o is 0, oe_o is 1 and nack_o is 0. This does not depend on os_tick_i.
- R3: The character is sent as follows. The start bit (0) lasts 16 os_tick_i pulses. Data bits 0 to 7 follow, least significant first, and each lasts 16 pulses. The parity bit follows for 16 pulses, and its value is the XOR of the 8 data bits (even parity). tx_o changes only at the clock edge of an os_tick_i pulse.
- R4: oe_o is 1 during the start bit, the data bits and the parity bit. It is 0 for the whole stop time, and tx_o is 1 during the stop time.
- R5: The stop time lasts 24 os_tick_i pulses. At the edge of the 24th pulse, busy_o falls and done_o rises. done_o stays high for exactly one clock.
- R6: The line input line_i is sampled only at the 16th, 17th and 18th os_tick_i pulses of the stop time. If at least two of the three samples are 0, nack_o is 1 from the edge of the 18th pulse. Otherwise it stays 0. Line values at any other tick have no effect.
- R7: nack_o keeps its value after the character ends and is cleared only when the next start is accepted.
- R8: For psc_i from 1 to 31, card_clk_o has a period of 2*psc_i clock cycles and is high for psc_i of them. For psc_i equal to 0, card_clk_o stays 0.
- R9: A start_i while busy_o is 1 is ignored. The character in progress continues with its original data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick_i | input | 1 | One-cycle 16x oversampling pulse |
| start_i | input | 1 | Start strobe for a new character |
| data_i | input | 8 | Byte to send, captured at the start |
| line_i | input | 1 | Sampled level of the shared I/O line |
| psc_i | input | 5 | Card clock prescale value (0 stops the clock) |
| tx_o | output | 1 | Level presented to the I/O pad |
| oe_o | output | 1 | Pad output enable, 1 while actively driving |
| busy_o | output | 1 | Character in progress |
| nack_o | output | 1 | Card signalled a parity error on the last character |
| done_o | output | 1 | One-cycle pulse at the end of a character |
| card_clk_o | output | 1 | Free-running clock for the card |

## Verification
The bench sends all 256 byte values. Each character returns one of the eight possible low/high patterns across the three sampling ticks. In half of the characters, the line is also pulled low at the ticks just before and just after that window. A design that samples one tick off, or that votes on any low sample, reports a NACK for the wrong patterns. A design that sends the data most significant first, computes odd parity, or keeps the pad driven during the stop time fails the mid-bit checks. Some characters get a second start strobe partway through; a design that reloads on it sends corrupted bits. The card clock is swept over every prescale value, including zero, and its period and high time are measured. That sweep catches an off-by-one in the division ratio and duty cycle that drifts from 50%.

// File: rtl/sc_tx_pkg.sv
// Shared types for the smartcard character transmitter.
// Assumes: one character in flight at a time.
package sc_tx_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } sc_phase_e;
endpackage

// File: rtl/sc_tx_seq.sv
// Character sequencer: walks start, data (LSB first), even parity and the
// released stop period, one bit per OS_RATE oversampling ticks.
// Assumes os_tick_i is a single-cycle pulse; start is taken only when idle.
module sc_tx_seq
    import sc_tx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OS_RATE    = 16,
    parameter int STOP_TICKS = 24,
    localparam int CNT_W     = $clog2(STOP_TICKS + 1),
    localparam int BIT_W     = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              tx_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              accept_o,
    output logic              stop_tick_o,
    output logic [CNT_W-1:0]  stop_idx_o
);
    sc_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] shr_q;
    logic              par_q;
    logic              bit_end;

    // Accept a new character only when nothing is in flight.
    assign accept_o = start_i && (phase_q == PH_IDLE);

    // Last tick of the current phase: stop period is longer than a bit.
    always_comb begin
        if (phase_q == PH_STOP) bit_end = (cnt_q == CNT_W'(STOP_TICKS - 1));
        else                    bit_end = (cnt_q == CNT_W'(OS_RATE - 1));
    end

    // Phase, tick counter, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            bit_q   <= '0;
            shr_q   <= '0;
            par_q   <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept_o) begin
                phase_q <= PH_START;
                cnt_q   <= '0;
                bit_q   <= '0;
                shr_q   <= data_i;
                par_q   <= ^data_i;
            end else if (os_tick_i && phase_q != PH_IDLE) begin
                if (!bit_end) begin
                    cnt_q <= cnt_q + 1'b1;
                end else begin
                    cnt_q <= '0;
                    unique case (phase_q)
                        PH_START: phase_q <= PH_DATA;
                        PH_DATA: begin
                            shr_q <= shr_q >> 1;
                            bit_q <= bit_q + 1'b1;
                            if (bit_q == BIT_W'(DATA_W - 1)) phase_q <= PH_PAR;
                        end
                        PH_PAR:  phase_q <= PH_STOP;
                        PH_STOP: begin
                            phase_q <= PH_IDLE;
                            done_o  <= 1'b1;
                        end
                        default: phase_q <= PH_IDLE;
                    endcase
                end
            end
        end
    end

    // Pad level and enable per phase; stop and idle release the line high.
    always_comb begin
        unique case (phase_q)
            PH_START: begin tx_o = 1'b0;     oe_o = 1'b1; end
            PH_DATA:  begin tx_o = shr_q[0]; oe_o = 1'b1; end
            PH_PAR:   begin tx_o = par_q;    oe_o = 1'b1; end
            default:  begin tx_o = 1'b1;     oe_o = 1'b0; end
        endcase
    end

    // Ordinal (1-based) of the current tick inside the stop period.
    assign busy_o      = (phase_q != PH_IDLE);
    assign stop_tick_o = os_tick_i && (phase_q == PH_STOP);
    assign stop_idx_o  = cnt_q + 1'b1;
endmodule

// File: rtl/sc_nack_vote.sv
// NACK detector: collects WIN_LEN line samples starting at stop-period tick
// WIN_FIRST and flags a NACK when a majority of them are low.
// Assumes stop_idx_i is valid whenever stop_tick_i is high.
module sc_nack_vote #(
    parameter int IDX_W     = 5,
    parameter int WIN_FIRST = 16,
    parameter int WIN_LEN   = 3,
    localparam int ZC_W     = $clog2(WIN_LEN + 1),
    localparam int WIN_LAST = WIN_FIRST + WIN_LEN - 1,
    localparam int MAJ      = WIN_LEN / 2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             stop_tick_i,
    input  logic [IDX_W-1:0] stop_idx_i,
    input  logic             line_i,
    output logic             nack_o
);
    logic [ZC_W-1:0] zeros_q;
    logic [ZC_W-1:0] zeros_nx;
    logic            in_win;
    logic            last_smp;

    // Window decode on the stop-period tick ordinal.
    assign in_win   = stop_tick_i && (stop_idx_i >= IDX_W'(WIN_FIRST))
                                  && (stop_idx_i <= IDX_W'(WIN_LAST));
    assign last_smp = (stop_idx_i == IDX_W'(WIN_LAST));
    assign zeros_nx = zeros_q + ZC_W'(!line_i);

    // Count low samples and resolve the vote on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zeros_q <= '0;
            nack_o  <= 1'b0;
        end else if (clear_i) begin
            zeros_q <= '0;
            nack_o  <= 1'b0;
        end else if (in_win) begin
            if (last_smp) begin
                zeros_q <= '0;
                nack_o  <= (zeros_nx >= ZC_W'(MAJ));
            end else begin
                zeros_q <= zeros_nx;
            end
        end
    end
endmodule

// File: rtl/sc_card_clkdiv.sv
// Card clock divider: toggles every psc_i cycles for a 2*psc_i period at
// 50% duty; psc_i of 0 parks the clock low. Adapts at once to a new psc_i.
module sc_card_clkdiv #(
    parameter int PSC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] psc_i,
    output logic             card_clk_o
);
    logic [PSC_W-1:0] cnt_q;

    // Half-period counter and output toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || psc_i == '0) begin
            cnt_q      <= '0;
            card_clk_o <= 1'b0;
        end else if (cnt_q >= psc_i - 1'b1) begin
            cnt_q      <= '0;
            card_clk_o <= !card_clk_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_char_tx.sv
// Top: smartcard character transmitter with stop-period NACK check and a
// card clock divider. Assumes line_i is already synchronised to clk.
module sc_char_tx #(
    parameter int DATA_W     = 8,
    parameter int OS_RATE    = 16,
    parameter int STOP_TICKS = 24,
    parameter int NACK_FIRST = 16,
    parameter int NACK_LEN   = 3,
    parameter int PSC_W      = 5,
    localparam int CNT_W     = $clog2(STOP_TICKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              line_i,
    input  logic [PSC_W-1:0]  psc_i,
    output logic              tx_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              nack_o,
    output logic              done_o,
    output logic              card_clk_o
);
    logic             accept;
    logic             stop_tick;
    logic [CNT_W-1:0] stop_idx;

    // Frame sequencing and pad control.
    sc_tx_seq #(
        .DATA_W(DATA_W), .OS_RATE(OS_RATE), .STOP_TICKS(STOP_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick_i), .start_i(start_i),
        .data_i(data_i), .tx_o(tx_o), .oe_o(oe_o), .busy_o(busy_o),
        .done_o(done_o), .accept_o(accept), .stop_tick_o(stop_tick),
        .stop_idx_o(stop_idx)
    );

    // Majority vote on the card's answer during the stop period.
    sc_nack_vote #(
        .IDX_W(CNT_W), .WIN_FIRST(NACK_FIRST), .WIN_LEN(NACK_LEN)
    ) u_vote (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .stop_tick_i(stop_tick),
        .stop_idx_i(stop_idx), .line_i(line_i), .nack_o(nack_o)
    );

    // Independent card clock.
    sc_card_clkdiv #(.PSC_W(PSC_W)) u_ckdiv (
        .clk(clk), .rst_n(rst_n), .psc_i(psc_i), .card_clk_o(card_clk_o)
    );
endmodule

// File: rtl/sc_char_tx_chk.sv
// Port-level property checker for sc_char_tx, attached by bind.
module sc_char_tx_chk #(
    parameter int DATA_W = 8,
    parameter int PSC_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              os_tick_i,
    input logic              start_i,
    input logic [DATA_W-1:0] data_i,
    input logic              line_i,
    input logic [PSC_W-1:0]  psc_i,
    input logic              tx_o,
    input logic              oe_o,
    input logic              busy_o,
    input logic              nack_o,
    input logic              done_o,
    input logic              card_clk_o
);
    // R1: idle means the line is released high.
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!oe_o && tx_o));

    // R2: an accepted start drives the start bit next cycle.
    p_start_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && oe_o && !tx_o && !nack_o));

    // R3: the pad level moves only on an oversampling tick.
    p_tx_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !os_tick_i) |=> $stable(tx_o));

    // R4: whenever the pad is released during a character it shows a 1.
    p_release_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !oe_o) |-> tx_o);

    // R5: done is a single-cycle pulse outside a character.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o ##1 !done_o));

    // R7: no start while idle leaves the verdict alone.
    p_nack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(nack_o));

    // R8: a zero prescale parks the card clock low.
    p_ck_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psc_i == '0) |=> !card_clk_o);

    // R9: a character in flight stays in flight despite a start strobe.
    p_busy_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !os_tick_i) |=> busy_o);

    wire unused_ok = ^{data_i, line_i};
endmodule

bind sc_char_tx sc_char_tx_chk #(.DATA_W(DATA_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/tb_sc_char_tx.sv
module tb_sc_char_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick_i = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] data_i = '0;
    logic       line_i = 1'b1;
    logic [4:0] psc_i = 5'd3;
    logic       tx_o, oe_o, busy_o, nack_o, done_o, card_clk_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic snap_done, snap_busy;

    always #2.5 clk = ~clk;   // 200 MHz

    sc_char_tx dut (
        .clk(clk), .rst_n(rst_n), .os_tick_i(os_tick_i), .start_i(start_i),
        .data_i(data_i), .line_i(line_i), .psc_i(psc_i), .tx_o(tx_o),
        .oe_o(oe_o), .busy_o(busy_o), .nack_o(nack_o), .done_o(done_o),
        .card_clk_o(card_clk_o)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // One oversampling pulse, then one quiet cycle; returns at a negedge.
    task automatic tick(input logic lv);
        line_i    = lv;
        os_tick_i = 1'b1;
        @(posedge clk); @(negedge clk);
        os_tick_i = 1'b0;
        snap_done = done_o;
        snap_busy = busy_o;
        line_i    = 1'b1;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic strobe(input logic [7:0] d);
        data_i  = d;
        start_i = 1'b1;
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send_frame(input int f, inout logic prev_nack);
        logic [7:0] d;
        logic [9:0] bits;
        logic [2:0] pat;
        int zeros;
        logic exp_nack;
        d    = 8'((f * 37 + 11) & 255);
        bits = {^d, d[7:0], 1'b0} ;
        pat  = 3'(f & 7);
        zeros = int'(pat[0]) + int'(pat[1]) + int'(pat[2]);
        exp_nack = (zeros >= 2);
        // R7: verdict of the previous character still held before the strobe
        chk(nack_o == prev_nack, "R7 nack held", nack_o, prev_nack);
        strobe(d);
        chk(busy_o && !tx_o && oe_o, "R2 start accepted", {busy_o, tx_o, oe_o}, 3'b101);
        chk(nack_o == 1'b0, "R2 nack cleared", nack_o, 0);
        for (int b = 0; b < 10; b++) begin
            for (int k = 1; k <= 16; k++) begin
                if (b == 5 && k == 1 && (f % 16) == 5) begin
                    strobe(~d);   // R9: must be ignored
                    chk(busy_o && tx_o == bits[b], "R9 start ignored", tx_o, bits[b]);
                end
                tick(1'b1);
                if (k == 8) begin
                    chk(tx_o == bits[b], "R3 bit value", tx_o, bits[b]);
                    chk(oe_o == 1'b1, "R4 driven during bit", oe_o, 1);
                end
            end
        end
        for (int n = 1; n <= 24; n++) begin
            logic lv;
            lv = 1'b1;
            if (n >= 16 && n <= 18) lv = !pat[n-16];
            else if (f[3] && (n == 15 || n >= 19)) lv = 1'b0;
            tick(lv);
            if (n == 1 || n == 12 || n == 23)
                chk(!oe_o && tx_o, "R4 released in stop", {oe_o, tx_o}, 2'b01);
            if (n == 18)
                chk(nack_o == exp_nack, "R6 nack vote", nack_o, exp_nack);
            if (n == 23)
                chk(snap_busy && !snap_done, "R5 stop not ended early", snap_busy, 1);
        end
        chk(snap_done && !snap_busy, "R5 done at 24th stop tick", {snap_done, snap_busy}, 2'b10);
        chk(!done_o, "R5 done single cycle", done_o, 0);
        chk(nack_o == exp_nack, "R6 nack after frame", nack_o, exp_nack);
        prev_nack = exp_nack;
    endtask

    task automatic measure_ck(input int p);
        int t, rise1, rise2, fall1;
        logic prev;
        psc_i = 5'(p);
        repeat (80) @(negedge clk);
        rise1 = -1; rise2 = -1; fall1 = -1;
        prev  = card_clk_o;
        for (t = 0; t < 200; t++) begin
            @(negedge clk);
            if (card_clk_o && !prev) begin
                if (rise1 < 0) rise1 = t;
                else if (rise2 < 0) rise2 = t;
            end
            if (!card_clk_o && prev && rise1 >= 0 && fall1 < 0) fall1 = t;
            if (p == 0) chk(!card_clk_o, "R8 parked", card_clk_o, 0);
            prev = card_clk_o;
        end
        if (p != 0) begin
            chk(rise2 - rise1 == 2 * p, "R8 period", rise2 - rise1, 2 * p);
            chk(fall1 - rise1 == p, "R8 high time", fall1 - rise1, p);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                errors++; checks++;
                $display("FAIL watchdog actual %0d expected %0d", cycles, 190000);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic pn;
        pn = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset values (psc nonzero but held in reset)
        chk(tx_o && !oe_o && !busy_o && !nack_o && !done_o && !card_clk_o,
            "R1 reset state", {tx_o, oe_o, busy_o, nack_o, done_o, card_clk_o}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int f = 0; f < 256; f++) begin
            send_frame(f, pn);
            @(negedge clk);
        end
        for (int p = 0; p < 32; p++) measure_ck(p);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule